// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from a set of on-chip peripheral lines and three external request pins and turns them into one normal interrupt request toward a processor core. A single dedicated external pin feeds a separate fast interrupt request output; no other source can reach that output. Every normal source has its own enable bit, a 3-bit priority and a trigger mode. Internal lines can be level or rising-edge sensed. External pins pass through a two-flop synchronizer and can be sensed on either edge or at either level.

Software works through a plain synchronous register port. It reads the vector register to acknowledge the winning source. The read returns that source's programmed handler address, clears an edge-latched request and pushes the source's priority onto an eight-entry nesting stack. While the stack holds a level, only a strictly higher priority raises the normal request again. An end-of-interrupt write pops the stack. A vector read made while the normal request is low returns a programmable spurious value and leaves the stack untouched.

Top module: `vpic_top`

## Requirements
- R1: After reset, `irq_req_o` and `fiq_req_o` are 0, the enable register (address 0) reads 0 and the nesting stack is empty.
- R2: A source whose enable bit (address 0, bit s for source s) is 0 never raises `irq_req_o`, although its request still shows in the pending register (address 2, bit s). Setting the enable bit raises the request.
- R3: Each normal source s has a configuration register at address 8+s, with priority in bits [2:0] and mode in bits [5:4], and a vector register at address 16+s. Among the pending enabled sources the highest priority wins, and a read of address 3 returns the winner's vector.
- R4: When pending enabled sources share the highest priority, the lowest source number wins.
- R5: An internal source (numbers 0 to N_INT-1) is active-high level sensed when mode bit 5 is 0 and rising-edge sensed when it is 1. Mode bit 4 has no effect on an internal source.
- R6: An external source (numbers N_INT and up) uses mode 00 = low level, 01 = high level, 10 = falling edge, 11 = rising edge. Its pin goes through a two-flop synchronizer, so a level change reaches the pending state on the second rising clock edge after it is applied.
- R7: An edge-sensed source latches a pending bit on the detected edge. The bit stays set after the input returns and is cleared by a vector read that selects that source, or by writing 1 to its bit in the clear register (address 1).
- R8: A vector read that acknowledges a source pushes that source's priority onto a stack of depth 8 and makes it the current level. While the stack is not empty, `irq_req_o` is raised only by a winner whose priority is strictly above the current level. A write to address 4 (end of interrupt) pops one entry, and such a write is ignored when the stack is empty.
- R9: A vector read made while `irq_req_o` is 0 returns the spurious register (address 5) and does not change the stack.
- R10: `fiq_req_o` is driven only by `fiq_i`, sensed with the R6 mode encoding in address 6 bits [1:0]. It is enabled by bit N_SRC of address 0, shown in bit N_SRC of address 2 and cleared (edge mode) by bit N_SRC of address 1. Normal sources never raise it, and `fiq_i` never raises `irq_req_o`.
- R11: Read data appears on `reg_rdata_o` on the clock edge that follows the cycle in which `reg_rd_i` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_irq_i | input | N_INT | On-chip peripheral interrupt lines, sources 0 to N_INT-1 |
| ext_irq_i | input | N_EXT | External request pins, sources N_INT to N_SRC-1 |
| fiq_i | input | 1 | External fast interrupt pin |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | VEC_W | Write data |
| reg_rdata_o | output | VEC_W | Registered read data |
| irq_req_o | output | 1 | Normal interrupt request to the core |
| fiq_req_o | output | 1 | Fast interrupt request to the core |

## Verification
The bench targets preemption at equal and higher priority: a design that compared with "greater or equal" would re-raise the request for a same-level source and nest without end. It acknowledges an edge source and then reads the pending register, which catches a design that leaves the latch set and would take the same interrupt twice. It checks the cycle on which a synchronized level first appears, so a missing or extra synchronizer stage shows up as a one-cycle shift. It also makes a vector read with nothing pending, followed by a priority-0 request: a design that pushed on the spurious read would hold that request back for good.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  localparam int PRIO_W = 3;

  // Trigger mode encoding, shared by external pins and the fast pin.
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  typedef struct packed {
    logic [1:0]        mode;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;

  localparam logic [4:0] A_ENABLE = 5'd0;
  localparam logic [4:0] A_CLEAR  = 5'd1;
  localparam logic [4:0] A_PEND   = 5'd2;
  localparam logic [4:0] A_VECTOR = 5'd3;
  localparam logic [4:0] A_EOI    = 5'd4;
  localparam logic [4:0] A_SPUR   = 5'd5;
  localparam logic [4:0] A_FMODE  = 5'd6;
  localparam int         A_CFG0   = 8;
  localparam int         A_VEC0   = 16;

endpackage

// File: rtl/vpic_src.sv
module vpic_src #(
  parameter bit IS_EXT = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       raw_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       pend_o
);

  logic smp;
  logic prev_q;
  logic edge_q, edge_d;
  logic pol, lvl, hit;

  generate
    if (IS_EXT) begin : g_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 2'b00;
        else         sync_q <= {sync_q[0], raw_i};
      end
      assign smp = sync_q[1];
      assign pol = mode_i[0];
    end else begin : g_direct
      assign smp = raw_i;
      assign pol = mode_i[0] | 1'b1;   // internal lines are always active-high
    end
  endgenerate

  always_comb begin
    lvl    = pol ? smp : ~smp;
    hit    = pol ? (smp & ~prev_q) : (~smp & prev_q);
    edge_d = edge_q;
    if (!mode_i[1])  edge_d = 1'b0;
    else if (hit)    edge_d = 1'b1;
    else if (clr_i)  edge_d = 1'b0;
    pend_o = mode_i[1] ? edge_q : lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= smp;
      edge_q <= edge_d;
    end
  end

  // R7: a detected edge is held
  a_r7_edge_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && hit) |=> edge_q);
  // R7: a clear with no new edge drops the latch
  a_r7_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && clr_i && !hit) |=> !edge_q);

endmodule

// File: rtl/vpic_prio.sv
module vpic_prio #(
  parameter int N   = 7,
  parameter int PW  = 3,
  parameter int IDW = 3
) (
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic                 found_o,
  output logic [IDW-1:0]       win_id_o,
  output logic [PW-1:0]        win_prio_o
);

  // Linear scan: strictly-greater comparison keeps the lower index on ties.
  always_comb begin
    found_o    = 1'b0;
    win_id_o   = '0;
    win_prio_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!found_o || (prio_i[i] > win_prio_o))) begin
        found_o    = 1'b1;
        win_id_o   = IDW'(i);
        win_prio_o = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/vpic_stack.sv
module vpic_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         nonempty_o,
  output logic         full_o
);

  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [CNTW-1:0]         cnt_q, cnt_d;
  logic [PTRW-1:0]         wr_idx, top_idx;
  logic                    do_push, do_pop;

  always_comb begin
    do_push    = push_i && !full_o;
    do_pop     = pop_i && nonempty_o && !push_i;
    wr_idx     = PTRW'(cnt_q);
    top_idx    = PTRW'(cnt_q - 1'b1);
    nonempty_o = (cnt_q != '0);
    full_o     = (cnt_q == CNTW'(DEPTH));
    top_o      = nonempty_o ? mem_q[top_idx] : '0;
    cnt_d      = cnt_q;
    if (do_push)     cnt_d = cnt_q + 1'b1;
    else if (do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mem_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (do_push) mem_q[wr_idx] <= data_i;
    end
  end

  // R8: strictly-higher preemption bounds nesting to the depth
  a_r8_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R8: a pop takes exactly one entry
  a_r8_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && nonempty_o && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int N_INT      = 4,
  parameter int N_EXT      = 3,
  parameter int VEC_W      = 32,
  parameter int NEST_DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_INT-1:0] int_irq_i,
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic             fiq_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [4:0]       reg_addr_i,
  input  logic [VEC_W-1:0] reg_wdata_i,
  output logic [VEC_W-1:0] reg_rdata_o,
  output logic             irq_req_o,
  output logic             fiq_req_o
);

  localparam int N_SRC = N_INT + N_EXT;
  localparam int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  // ---------------- reset synchronizer ----------------
  logic [1:0] rst_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n = rst_q[1];

  // ---------------- state ----------------
  logic [N_SRC:0]      en_q, en_d;
  logic [VEC_W-1:0]    spur_q, spur_d;
  logic [1:0]          fmode_q, fmode_d;
  src_cfg_t            cfg_q [N_SRC];
  src_cfg_t            cfg_d [N_SRC];
  logic [VEC_W-1:0]    vec_q [N_SRC];
  logic [VEC_W-1:0]    vec_d [N_SRC];
  logic [VEC_W-1:0]    rdata_q, rdata_d;

  logic [N_SRC:0]      clr_wr;
  logic [N_SRC-1:0]    src_clr, src_pend, src_req;
  logic [N_SRC-1:0][PRIO_W-1:0] src_prio;
  logic                fiq_pend;
  logic                eoi, ack, spur_rd;
  logic                found;
  logic [IDW-1:0]      win_id;
  logic [PRIO_W-1:0]   win_prio, cur_level;
  logic                stk_nonempty, stk_full;

  // ---------------- source front ends ----------------
  genvar s;
  generate
    for (s = 0; s < N_SRC; s++) begin : g_src
      logic raw;
      if (s < N_INT) begin : g_int
        assign raw = int_irq_i[s];
      end else begin : g_ext
        assign raw = ext_irq_i[s - N_INT];
      end
      vpic_src #(.IS_EXT(s >= N_INT)) u_src (
        .clk_i  (clk_i),
        .rst_ni (rst_n),
        .raw_i  (raw),
        .mode_i (cfg_q[s].mode),
        .clr_i  (src_clr[s]),
        .pend_o (src_pend[s])
      );
      assign src_prio[s] = cfg_q[s].prio;
      assign src_req[s]  = src_pend[s] & en_q[s];
      assign src_clr[s]  = clr_wr[s] | (ack && (win_id == IDW'(s)));
    end
  endgenerate

  vpic_src #(.IS_EXT(1'b1)) u_fiq_src (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .raw_i  (fiq_i),
    .mode_i (fmode_q),
    .clr_i  (clr_wr[N_SRC]),
    .pend_o (fiq_pend)
  );

  // ---------------- arbitration and nesting ----------------
  vpic_prio #(.N(N_SRC), .PW(PRIO_W), .IDW(IDW)) u_prio (
    .req_i      (src_req),
    .prio_i     (src_prio),
    .found_o    (found),
    .win_id_o   (win_id),
    .win_prio_o (win_prio)
  );

  vpic_stack #(.DEPTH(NEST_DEPTH), .W(PRIO_W)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .push_i     (ack),
    .pop_i      (eoi),
    .data_i     (win_prio),
    .top_o      (cur_level),
    .nonempty_o (stk_nonempty),
    .full_o     (stk_full)
  );

  assign irq_req_o = found && (!stk_nonempty || (win_prio > cur_level));
  assign fiq_req_o = en_q[N_SRC] && fiq_pend;

  // ---------------- register port: next state ----------------
  always_comb begin
    en_d    = en_q;
    spur_d  = spur_q;
    fmode_d = fmode_q;
    cfg_d   = cfg_q;
    vec_d   = vec_q;
    clr_wr  = '0;
    eoi     = 1'b0;
    if (reg_wr_i) begin
      case (reg_addr_i)
        A_ENABLE: en_d    = reg_wdata_i[N_SRC:0];
        A_CLEAR:  clr_wr  = reg_wdata_i[N_SRC:0];
        A_EOI:    eoi     = 1'b1;
        A_SPUR:   spur_d  = reg_wdata_i;
        A_FMODE:  fmode_d = reg_wdata_i[1:0];
        default: begin
          for (int i = 0; i < N_SRC; i++) begin
            if (reg_addr_i == 5'(A_CFG0 + i)) begin
              cfg_d[i].mode = reg_wdata_i[5:4];
              cfg_d[i].prio = reg_wdata_i[PRIO_W-1:0];
            end
            if (reg_addr_i == 5'(A_VEC0 + i)) vec_d[i] = reg_wdata_i;
          end
        end
      endcase
    end
  end

  always_comb begin
    spur_rd = reg_rd_i && (reg_addr_i == A_VECTOR) && !irq_req_o;
    ack     = reg_rd_i && (reg_addr_i == A_VECTOR) && irq_req_o;
    rdata_d = '0;
    case (reg_addr_i)
      A_ENABLE: rdata_d = VEC_W'(en_q);
      A_PEND:   rdata_d = VEC_W'({fiq_pend, src_pend});
      A_VECTOR: rdata_d = irq_req_o ? vec_q[win_id] : spur_q;
      A_SPUR:   rdata_d = spur_q;
      A_FMODE:  rdata_d = VEC_W'(fmode_q);
      default: begin
        for (int i = 0; i < N_SRC; i++) begin
          if (reg_addr_i == 5'(A_CFG0 + i))
            rdata_d = VEC_W'({cfg_q[i].mode, 1'b0, cfg_q[i].prio});
          if (reg_addr_i == 5'(A_VEC0 + i)) rdata_d = vec_q[i];
        end
      end
    endcase
  end

  // ---------------- register port: registers ----------------
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      spur_q  <= '0;
      fmode_q <= TRIG_HIGH;
      rdata_q <= '0;
      for (int i = 0; i < N_SRC; i++) begin
        cfg_q[i] <= '{mode: TRIG_HIGH, prio: '0};
        vec_q[i] <= '0;
      end
    end else begin
      if (reg_wr_i) begin
        en_q    <= en_d;
        spur_q  <= spur_d;
        fmode_q <= fmode_d;
        cfg_q   <= cfg_d;
        vec_q   <= vec_d;
      end
      if (reg_rd_i) rdata_q <= rdata_d;
    end
  end

  assign reg_rdata_o = rdata_q;

  // ---------------- assertions ----------------
  // R1: outputs low in the first cycle after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk_i)
    $rose(rst_n) |-> (!irq_req_o && !fiq_req_o && !stk_nonempty));
  // R2: the normal request needs an enabled pending source
  a_r2_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_req_o |-> ((en_q[N_SRC-1:0] & src_pend) != '0));
  // R3: the arbiter winner is itself enabled and pending
  a_r3_winner_live: assert property (@(posedge clk_i) disable iff (!rst_n)
    found |-> (src_pend[win_id] && en_q[win_id]));
  // R4: no lower-numbered contender holds an equal or higher priority
  generate
    for (s = 0; s < N_SRC; s++) begin : g_tie_chk
      a_r4_lower_index: assert property (@(posedge clk_i) disable iff (!rst_n)
        (found && src_req[s] && (IDW'(s) < win_id)) |-> (src_prio[s] < win_prio));
    end
  endgenerate
  // R8: nested acknowledge strictly raises the current level
  a_r8_level_rises: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ack && stk_nonempty) |=> (cur_level > $past(cur_level)));
  // R9: a spurious read returns the spurious value and keeps the stack
  a_r9_spurious_value: assert property (@(posedge clk_i) disable iff (!rst_n)
    spur_rd |=> (reg_rdata_o == $past(spur_q)));
  a_r9_stack_kept: assert property (@(posedge clk_i) disable iff (!rst_n)
    (spur_rd && !reg_wr_i) |=> ($stable(stk_nonempty) && $stable(cur_level)));
  // R10: the fast request comes only from the fast pin path
  a_r10_fiq_source: assert property (@(posedge clk_i) disable iff (!rst_n)
    fiq_req_o |-> fiq_pend);

endmodule

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;

  localparam int N_INT = 4;
  localparam int N_EXT = 3;
  localparam int N_SRC = N_INT + N_EXT;
  localparam logic [31:0] SPUR = 32'h0000_DEAD;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N_INT-1:0] int_irq;
  logic [N_EXT-1:0] ext_irq;
  logic             fiq;
  logic             reg_wr, reg_rd;
  logic [4:0]       reg_addr;
  logic [31:0]      reg_wdata, reg_rdata;
  logic             irq_req, fiq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vpic_top #(.N_INT(N_INT), .N_EXT(N_EXT), .VEC_W(32), .NEST_DEPTH(8)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .int_irq_i   (int_irq),
    .ext_irq_i   (ext_irq),
    .fiq_i       (fiq),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_req_o   (irq_req),
    .fiq_req_o   (fiq_req)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] vec_of(input int s);
    return 32'h100 + 32'(s * 4);
  endfunction

  function automatic logic [31:0] cfg(input logic [1:0] mode, input logic [2:0] prio);
    return {26'b0, mode, 1'b0, prio};
  endfunction

  // R1
  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq after reset", 32'(irq_req), 0);
    check("R1 fiq after reset", 32'(fiq_req), 0);
    rd(5'd0, d);
    check("R1 enable reads zero", d, 0);
    for (int s = 0; s < N_SRC; s++) wr(5'(16 + s), vec_of(s));
    wr(5'd5, SPUR);
  endtask

  // R2, R11
  task automatic t_mask();
    logic [31:0] d;
    wr(5'd8, cfg(2'b01, 3'd3));
    int_irq[0] = 1'b1;
    cyc(2);
    check("R2 disabled source silent", 32'(irq_req), 0);
    rd(5'd2, d);
    check("R2 pending visible while masked", d & 32'h1, 32'h1);
    wr(5'd0, 32'h1);
    cyc(1);
    check("R2 enabled source raises irq", 32'(irq_req), 1);
    rd(5'd3, d);
    check("R11 vector read data", d, vec_of(0));
    wr(5'd4, 0);
    int_irq[0] = 1'b0;
    wr(5'd0, 0);
  endtask

  // R3, R4
  task automatic t_prio();
    logic [31:0] d;
    wr(5'd9,  cfg(2'b01, 3'd2));
    wr(5'd10, cfg(2'b01, 3'd5));
    int_irq[2:1] = 2'b11;
    wr(5'd0, 32'h6);
    rd(5'd3, d);
    check("R3 highest priority vector", d, vec_of(2));
    wr(5'd4, 0);
    wr(5'd10, cfg(2'b01, 3'd2));
    rd(5'd3, d);
    check("R4 tie goes to lower number", d, vec_of(1));
    wr(5'd4, 0);
    int_irq[2:1] = 2'b00;
    wr(5'd0, 0);
  endtask

  // R5, R7
  task automatic t_int_edge();
    logic [31:0] d;
    wr(5'd11, cfg(2'b11, 3'd1));
    wr(5'd0, 32'h8);
    @(negedge clk); int_irq[3] = 1'b1;
    @(negedge clk); int_irq[3] = 1'b0;
    cyc(2);
    check("R5 internal rising edge latched", 32'(irq_req), 1);
    rd(5'd3, d);
    check("R7 edge source vector", d, vec_of(3));
    rd(5'd2, d);
    check("R7 vector read clears edge latch", d & 32'h8, 0);
    wr(5'd4, 0);
    wr(5'd11, cfg(2'b10, 3'd1));
    @(negedge clk); int_irq[3] = 1'b1;
    cyc(2);
    check("R5 mode bit 4 ignored on internal (rising)", 32'(irq_req), 1);
    int_irq[3] = 1'b0;
    cyc(2);
    check("R7 latch held after input falls", 32'(irq_req), 1);
    wr(5'd1, 32'h8);
    cyc(1);
    check("R7 clear register drops latch", 32'(irq_req), 0);
    wr(5'd0, 0);
  endtask

  // R6
  task automatic t_ext();
    logic [31:0] d;
    wr(5'd12, cfg(2'b00, 3'd1));
    wr(5'd0, 32'h10);
    cyc(3);
    check("R6 low level active on low pin", 32'(irq_req), 1);
    ext_irq[0] = 1'b1;
    cyc(3);
    check("R6 low level idle on high pin", 32'(irq_req), 0);
    ext_irq[0] = 1'b0;
    wr(5'd0, 0);
    wr(5'd13, cfg(2'b01, 3'd1));
    wr(5'd0, 32'h20);
    @(negedge clk); ext_irq[1] = 1'b1;
    @(negedge clk);
    check("R6 synchronizer: not yet after one edge", 32'(irq_req), 0);
    @(negedge clk);
    check("R6 synchronizer: seen after two edges", 32'(irq_req), 1);
    ext_irq[1] = 1'b0;
    wr(5'd0, 0);
    wr(5'd14, cfg(2'b10, 3'd1));
    wr(5'd0, 32'h40);
    ext_irq[2] = 1'b1;
    cyc(4);
    check("R6 falling mode ignores rise", 32'(irq_req), 0);
    ext_irq[2] = 1'b0;
    cyc(4);
    check("R6 falling edge latched", 32'(irq_req), 1);
    wr(5'd1, 32'h40);
    rd(5'd2, d);
    check("R6 falling latch cleared", d & 32'h40, 0);
    wr(5'd0, 0);
  endtask

  // R8
  task automatic t_nest();
    logic [31:0] d;
    wr(5'd8,  cfg(2'b01, 3'd2));
    wr(5'd9,  cfg(2'b01, 3'd2));
    wr(5'd10, cfg(2'b01, 3'd6));
    wr(5'd0, 32'h7);
    int_irq[0] = 1'b1;
    rd(5'd3, d);
    check("R8 first level vector", d, vec_of(0));
    int_irq[1] = 1'b1;
    cyc(1);
    check("R8 equal priority does not preempt", 32'(irq_req), 0);
    int_irq[2] = 1'b1;
    cyc(1);
    check("R8 higher priority preempts", 32'(irq_req), 1);
    rd(5'd3, d);
    check("R8 nested vector", d, vec_of(2));
    cyc(1);
    check("R8 held at level 6", 32'(irq_req), 0);
    wr(5'd4, 0);
    check("R8 pop returns to level 2", 32'(irq_req), 1);
    int_irq[2] = 1'b0;
    cyc(1);
    check("R8 level 2 blocks priority 2", 32'(irq_req), 0);
    wr(5'd4, 0);
    check("R8 empty stack lets any winner through", 32'(irq_req), 1);
    wr(5'd4, 0);
    rd(5'd3, d);
    check("R8 acknowledge after extra end-of-interrupt", d, vec_of(0));
    wr(5'd4, 0);
    int_irq[1:0] = 2'b00;
    wr(5'd0, 0);
  endtask

  // R9
  task automatic t_spur();
    logic [31:0] d;
    wr(5'd8, cfg(2'b01, 3'd3));
    wr(5'd9, cfg(2'b01, 3'd0));
    int_irq[0] = 1'b1;
    wr(5'd0, 32'h1);
    rd(5'd3, d);
    check("R9 setup acknowledge", d, vec_of(0));
    wr(5'd0, 0);
    rd(5'd3, d);
    check("R9 spurious value", d, SPUR);
    wr(5'd4, 0);
    int_irq[1] = 1'b1;
    wr(5'd0, 32'h2);
    check("R9 spurious read left stack empty", 32'(irq_req), 1);
    int_irq[1:0] = 2'b00;
    wr(5'd0, 0);
  endtask

  // R10
  task automatic t_fiq();
    logic [31:0] d;
    wr(5'd6, 32'h3);
    wr(5'd8, cfg(2'b01, 3'd0));
    int_irq[0] = 1'b1;
    wr(5'd0, 32'h81);
    cyc(1);
    check("R10 normal source never raises fiq", 32'(fiq_req), 0);
    @(negedge clk); fiq = 1'b1;
    @(negedge clk); fiq = 1'b0;
    cyc(4);
    check("R10 fast pin rising edge", 32'(fiq_req), 1);
    int_irq[0] = 1'b0;
    cyc(1);
    check("R10 fast pin does not raise irq", 32'(irq_req), 0);
    rd(5'd2, d);
    check("R10 fast pending bit", d & 32'h80, 32'h80);
    wr(5'd1, 32'h80);
    cyc(1);
    check("R10 fast clear", 32'(fiq_req), 0);
  endtask

  initial begin
    rst_n = 1'b0; int_irq = '0; ext_irq = '0; fiq = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_mask();
    t_prio();
    t_int_edge();
    t_ext();
    t_nest();
    t_spur();
    t_fiq();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule